// File: doc/BRIEF.md
# Loss-of-Delineation Alarm Soak Timer

This block decides when a receive-side loss-of-cell-delineation condition has gone on long enough to justify a path remote defect indication toward the far end. It samples the loss condition only on a 125 µs timing strobe. It counts consecutive strobes on which the condition is present. When that count spans the programmed soak time, it raises a request that the transmit overhead inserter turns into the remote defect bit.

An 8-bit soak register holds the persistence time, in units of one strobe interval. Reset loads it with 32, which is 4 ms. An enable input gates the whole feature. When the enable is low, no request is ever raised, and any count in progress is discarded.

The block is a four-state machine. ST_OFF means the feature is disabled. ST_IDLE means no loss has been seen. ST_SOAK means loss is persisting and the counter is running. ST_ALARM means the request is raised. The transitions are:

- T_EN_ON: ST_OFF to ST_IDLE, when the enable is high.
- T_EN_OFF: any state to ST_OFF, when the enable is low.
- T_LOSS_SEEN: ST_IDLE to ST_SOAK, on a strobe with loss present and a nonzero soak value.
- T_IMMEDIATE: ST_IDLE to ST_ALARM, on a strobe with loss present and a soak value of zero.
- T_CLEAR: ST_SOAK to ST_IDLE, on a strobe without loss.
- T_RESTART: ST_SOAK to ST_IDLE, on a soak write.
- T_EXPIRE: ST_SOAK to ST_ALARM, on the strobe that completes the soak time.
- T_RECOVER: ST_ALARM to ST_IDLE, on a strobe without loss.

Top module: `rdi_soak_timer`

## Requirements
- R1: `rdi_req` is 0 after reset. With enable high and loss present, `rdi_req` rises in the cycle after the (S+1)-th consecutive strobe that samples loss high, where S is the soak value. It stays 0 after all earlier strobes.
- R2: While `enable` is 0, `rdi_req` is 0 from the cycle after `enable` falls. After `enable` rises again, a complete soak period must elapse before `rdi_req` is raised.
- R3: The soak register is 8 bits wide and resets to 32 (4 ms at 125 µs per count). With no write after reset, the request rises after the 33rd consecutive loss strobe.
- R4: A cycle with `soak_wr` = 1 loads `soak_wdata` into the soak register. Every later soak period uses the new value.
- R5: A strobe that samples loss low during soaking clears the persistence count. A full new soak period is then required.
- R6: In the alarm state, `rdi_req` falls in the cycle after the first strobe that samples loss low.
- R7: With a soak value of 0, `rdi_req` rises in the cycle after the first strobe that samples loss high.
- R8: A soak write while soaking restarts the persistence count from zero. A strobe in the same cycle as a write is not counted. A soak write while in the alarm state leaves `rdi_req` at 1.
- R9: The loss input is examined only in cycles where `tick` is 1. Changes of loss between strobes do not affect the count or `rdi_req`.
- R10: The largest soak value, 255, raises `rdi_req` after the 256th consecutive loss strobe and not before.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | One-cycle strobe every 125 µs |
| loss | input | 1 | Loss-of-cell-delineation condition from the receive side |
| enable | input | 1 | Enables the remote defect indication feature |
| soak_wr | input | 1 | Write strobe for the soak register |
| soak_wdata | input | 8 | New soak value, in strobe intervals |
| rdi_req | output | 1 | Remote defect indication request to the transmit side |

## Verification
The assertions check several properties on every cycle. The request can only rise right after an enabled strobe that sampled loss high, and it can only fall after a loss-free strobe or a disable. A low enable silences the output. State and count stay frozen between strobes. The count stays below the soak value while soaking. A soak write lands in the register and aborts a running soak. Only the bench scenarios can show the exact strobe on which the alarm rises. The bench covers the reset default of 32, the boundary values 0 and 255, and the requirement that an interrupted or restarted soak takes a complete new period.

// File: rtl/soak_pkg.sv
`timescale 1ns/1ps
package soak_pkg;

    // Controller states of the persistence timer
    typedef enum logic [1:0] {
        ST_OFF   = 2'd0,
        ST_IDLE  = 2'd1,
        ST_SOAK  = 2'd2,
        ST_ALARM = 2'd3
    } soak_state_e;

    localparam int unsigned SOAK_W_DEF   = 8;
    localparam int unsigned SOAK_RST_DEF = 32;

endpackage

// File: rtl/soak_cfg_reg.sv
`timescale 1ns/1ps
module soak_cfg_reg #(
    parameter int unsigned W       = 8,
    parameter int unsigned RST_VAL = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] soak_q
);

    localparam logic [W-1:0] RST_CODE = W'(RST_VAL);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            soak_q <= RST_CODE;
        end else if (wr) begin
            soak_q <= wdata;
        end
    end

    AST_CFG_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        wr |=> (soak_q == $past(wdata))) else $error("soak write not taken"); // R4

endmodule

// File: rtl/soak_persist_cnt.sv
`timescale 1ns/1ps
module soak_persist_cnt #(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         inc,
    input  logic [W-1:0] soak,
    output logic [W-1:0] cnt_q,
    output logic         expire
);

    localparam int unsigned XW = W + 1;

    logic [XW-1:0] cnt_plus;

    always_comb begin
        cnt_plus = {1'b0, cnt_q} + XW'(1);
        expire   = (cnt_plus >= {1'b0, soak});
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clr) begin
            cnt_q <= '0;
        end else if (inc) begin
            cnt_q <= cnt_plus[W-1:0];
        end
    end

endmodule

// File: rtl/soak_fsm.sv
`timescale 1ns/1ps
module soak_fsm
    import soak_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        enable,
    input  logic        tick,
    input  logic        loss,
    input  logic        wr,
    input  logic        soak_zero,
    input  logic        expire,
    output soak_state_e state_q,
    output logic        cnt_clr,
    output logic        cnt_inc,
    output logic        rdi
);

    soak_state_e state_d;

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_OFF;
        end else begin
            state_q <= state_d;
        end
    end

    // Next-state selection
    always_comb begin
        state_d = state_q;
        if (!enable) begin
            state_d = ST_OFF;                                  // T_EN_OFF
        end else begin
            unique case (state_q)
                ST_OFF: begin
                    state_d = ST_IDLE;                         // T_EN_ON
                end
                ST_IDLE: begin
                    if (!wr && tick && loss) begin
                        state_d = soak_zero ? ST_ALARM         // T_IMMEDIATE
                                            : ST_SOAK;         // T_LOSS_SEEN
                    end
                end
                ST_SOAK: begin
                    if (wr) begin
                        state_d = ST_IDLE;                     // T_RESTART
                    end else if (tick) begin
                        if (!loss) begin
                            state_d = ST_IDLE;                 // T_CLEAR
                        end else if (expire) begin
                            state_d = ST_ALARM;                // T_EXPIRE
                        end
                    end
                end
                ST_ALARM: begin
                    if (tick && !loss) begin
                        state_d = ST_IDLE;                     // T_RECOVER
                    end
                end
                default: state_d = ST_OFF;
            endcase
        end
    end

    // Outputs
    always_comb begin
        rdi     = (state_q == ST_ALARM);
        cnt_clr = (state_d != ST_SOAK);
        cnt_inc = (state_q == ST_SOAK) && (state_d == ST_SOAK) && tick && loss;
    end

    AST_OFF_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> !rdi) else $error("request while disabled"); // R2
    AST_RESTART_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && wr && state_q == ST_SOAK) |=> (state_q == ST_IDLE)) else $error("write did not restart"); // R8

endmodule

// File: rtl/rdi_soak_timer.sv
`timescale 1ns/1ps
module rdi_soak_timer
    import soak_pkg::*;
#(
    parameter int unsigned SOAK_W   = SOAK_W_DEF,
    parameter int unsigned SOAK_RST = SOAK_RST_DEF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              loss,
    input  logic              enable,
    input  logic              soak_wr,
    input  logic [SOAK_W-1:0] soak_wdata,
    output logic              rdi_req
);

    logic [SOAK_W-1:0] soak_val;
    logic [SOAK_W-1:0] persist_cnt;
    logic              cnt_expire;
    logic              cnt_clr;
    logic              cnt_inc;
    soak_state_e       st;

    soak_cfg_reg #(.W(SOAK_W), .RST_VAL(SOAK_RST)) u_cfg (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr     (soak_wr),
        .wdata  (soak_wdata),
        .soak_q (soak_val)
    );

    soak_persist_cnt #(.W(SOAK_W)) u_cnt (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (cnt_clr),
        .inc    (cnt_inc),
        .soak   (soak_val),
        .cnt_q  (persist_cnt),
        .expire (cnt_expire)
    );

    soak_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .enable    (enable),
        .tick      (tick),
        .loss      (loss),
        .wr        (soak_wr),
        .soak_zero (soak_val == '0),
        .expire    (cnt_expire),
        .state_q   (st),
        .cnt_clr   (cnt_clr),
        .cnt_inc   (cnt_inc),
        .rdi       (rdi_req)
    );

    AST_RISE_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rdi_req) |-> $past(enable && tick && loss && !soak_wr)) else $error("request rose without loss strobe"); // R1
    AST_FALL_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(rdi_req) |-> $past(!enable || (tick && !loss))) else $error("request fell without cause"); // R6
    AST_CNT_BELOW_SOAK: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_SOAK) |-> (persist_cnt < soak_val)) else $error("count passed soak value"); // R5
    AST_HOLD_BETWEEN_TICKS: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && !tick && !soak_wr && st != ST_OFF) |=> ($stable(st) && $stable(persist_cnt))) else $error("state moved without strobe"); // R9
    AST_ZERO_SOAK: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && st == ST_IDLE && tick && loss && !soak_wr && soak_val == '0) |=> rdi_req) else $error("zero soak not immediate"); // R7

endmodule

// File: tb/sim_rdi_soak_timer.sv
`timescale 1ns/1ps
module sim_rdi_soak_timer;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick = 1'b0;
    logic       loss = 1'b0;
    logic       enable = 1'b0;
    logic       soak_wr = 1'b0;
    logic [7:0] soak_wdata = 8'd0;
    logic       rdi_req;

    int total = 0;
    int bad = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    rdi_soak_timer u0 (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick       (tick),
        .loss       (loss),
        .enable     (enable),
        .soak_wr    (soak_wr),
        .soak_wdata (soak_wdata),
        .rdi_req    (rdi_req)
    );

    task automatic chk(input string req, input logic got, input logic exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s rdi_req=%0b expected=%0b at %0t", req, got, exp, $time);
        end
    endtask

    // One strobe with the given loss value; output sampled the next falling edge
    task automatic strobe(input logic l);
        repeat (2) @(negedge clk);
        loss = l;
        tick = 1'b1;
        @(negedge clk);
        tick = 1'b0;
    endtask

    task automatic write_soak(input logic [7:0] v);
        @(negedge clk);
        soak_wdata = v;
        soak_wr = 1'b1;
        @(negedge clk);
        soak_wr = 1'b0;
    endtask

    // Run n loss strobes expecting no request, then one more expecting it
    task automatic soak_run(input string req, input int n);
        for (int i = 0; i < n; i++) begin
            strobe(1'b1);
            chk(req, rdi_req, 1'b0);
        end
        strobe(1'b1);
        chk(req, rdi_req, 1'b1);
    endtask

    task automatic t_reset_default;
        chk("R1 reset", rdi_req, 1'b0);
        enable = 1'b1;
        @(negedge clk);
        soak_run("R3 default 32", 32);
    endtask

    task automatic t_recover;
        strobe(1'b0);
        chk("R6 recover", rdi_req, 1'b0);
    endtask

    task automatic t_interrupt;
        write_soak(8'd5);
        for (int i = 0; i < 4; i++) strobe(1'b1);
        chk("R5 before gap", rdi_req, 1'b0);
        strobe(1'b0);
        soak_run("R5 full period again", 5);
        t_recover();
    endtask

    task automatic t_zero;
        write_soak(8'd0);
        strobe(1'b1);
        chk("R7 zero soak", rdi_req, 1'b1);
        strobe(1'b0);
        chk("R7 zero soak drop", rdi_req, 1'b0);
    endtask

    task automatic t_enable;
        write_soak(8'd3);
        soak_run("R4 new value 3", 3);
        @(negedge clk);
        enable = 1'b0;
        @(negedge clk);
        chk("R2 disable drops", rdi_req, 1'b0);
        for (int i = 0; i < 6; i++) begin
            strobe(1'b1);
            chk("R2 disabled", rdi_req, 1'b0);
        end
        enable = 1'b1;
        @(negedge clk);
        soak_run("R2 full period after enable", 3);
        t_recover();
    endtask

    task automatic t_restart;
        write_soak(8'd4);
        for (int i = 0; i < 3; i++) strobe(1'b1);
        // write coinciding with a loss strobe: strobe not counted
        @(negedge clk);
        soak_wdata = 8'd4;
        soak_wr = 1'b1;
        loss = 1'b1;
        tick = 1'b1;
        @(negedge clk);
        soak_wr = 1'b0;
        tick = 1'b0;
        chk("R8 write restarts", rdi_req, 1'b0);
        soak_run("R8 restart full period", 4);
        write_soak(8'd10);
        chk("R8 write in alarm", rdi_req, 1'b1);
        t_recover();
    endtask

    task automatic t_between;
        write_soak(8'd2);
        strobe(1'b1);
        loss = 1'b0;
        repeat (3) @(negedge clk);
        loss = 1'b1;
        strobe(1'b1);
        chk("R9 glitch ignored", rdi_req, 1'b0);
        strobe(1'b1);
        chk("R9 glitch ignored", rdi_req, 1'b1);
        loss = 1'b0;
        repeat (4) @(negedge clk);
        chk("R9 alarm holds between strobes", rdi_req, 1'b1);
        strobe(1'b0);
        chk("R6 drop after strobe", rdi_req, 1'b0);
    endtask

    task automatic t_max;
        write_soak(8'd255);
        soak_run("R10 max soak", 255);
        t_recover();
    endtask

    task automatic report;
        if (!finished) begin
            finished = 1'b1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset_default();
        t_recover();
        t_interrupt();
        t_zero();
        t_enable();
        t_restart();
        t_between();
        t_max();
        report();
    end

    initial begin
        repeat (150000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog expired");
        report();
    end

endmodule